// File: doc/BRIEF.md
# Dual-Role SPI Byte Port

This block moves one byte at a time over a four-wire serial link, either driving the serial clock itself (master) or following a clock that arrives from outside (slave). A single shift register serves both directions: the byte the host writes is sent MSB first, and the bits coming back replace it one by one. When eight bits have moved, the received byte is copied into a read buffer. A buffer-full flag and a completion interrupt flag are raised at that point. Write-collision and receive-overflow flags catch writes made while a transfer runs and bytes lost because the host had not yet read the previous one.

Three configuration inputs set the bus timing. Clock polarity sets the idle level of the serial clock. Edge select chooses whether outgoing data changes on the trailing clock edge (value 1) or on the leading edge (value 0). Sample select chooses whether the master captures incoming data in the middle or at the end of each bit. In master mode the serial clock runs at the module clock divided by 4, 16 or 64. A module clock enable freezes a master transfer in place. The transfer carries on from the same half-bit once the enable returns. In slave mode the logic follows the external clock and does not depend on that enable.

Top module: `spi_port`

## Requirements
- R1: Reset (active-low, asynchronous) clears buf_full, wcol, rxov and irq, stops any transfer and returns sck_out to the idle level given by cpol.
- R2: In master mode a write to an idle, enabled port sends wr_data MSB first on sdo. With cke=1 each bit is valid before the leading (idle-to-active) sck edge and changes on the trailing edge. With cke=0 each bit changes on the leading edge and is valid at the trailing edge. sck idles at the cpol level.
- R3: In master mode, smp=0 captures sdi at the middle of each bit: the leading edge when cke=1 and the trailing edge when cke=0. smp=1 captures sdi at the end of each bit. The eight captured bits, first bit as MSB, form the received byte.
- R4: In slave mode (is_master=0) the port follows sck_in. With cke=1 it samples sdi on the leading edge and shifts on the trailing edge. With cke=0 it shifts on the leading edge and samples on the trailing edge. It raises irq after the eighth trailing edge. clk_en has no effect in slave mode.
- R5: div_sel 0, 1 and 2 select a bit period of 4, 16 and 64 module clocks, and div_sel 3 also selects 64. A master transfer with clk_en held high raises irq exactly 8 bit periods after the write edge.
- R6: While clk_en is low during a master transfer, sck_out and sdo hold their values. The transfer resumes from the same point when clk_en returns, and it delivers the same bytes as an uninterrupted transfer.
- R7: A write while a transfer is in progress sets wcol and leaves the shift register untouched, so the byte being sent is unchanged.
- R8: A completed byte that arrives while buf_full is still set and rd_en is low sets rxov, raises irq and leaves rd_data holding the older byte.
- R9: Completion loads rd_data and sets buf_full and irq. rd_en clears buf_full. clr_flags clears wcol, rxov and irq.
- R10: Driving en low aborts a master transfer: sck_out returns to idle at once and no completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Module clock enable; low freezes master timing |
| en | input | 1 | Port enable; low aborts any transfer |
| is_master | input | 1 | 1 = master, 0 = slave |
| cpol | input | 1 | Serial clock idle level |
| cke | input | 1 | Edge select: 1 = data changes on trailing edge, 0 = on leading edge |
| smp | input | 1 | Master sample point: 0 = mid-bit, 1 = end of bit |
| div_sel | input | 2 | Master bit period: 4, 16, 64, 64 module clocks |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | DW | Byte to send |
| rd_en | input | 1 | Read strobe, clears buf_full |
| rd_data | output | DW | Last received byte |
| clr_flags | input | 1 | Clears wcol, rxov and irq |
| buf_full | output | 1 | Unread received byte present |
| wcol | output | 1 | Write collision flag |
| rxov | output | 1 | Receive overflow flag |
| irq | output | 1 | Transfer complete flag |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_in | input | 1 | External serial clock used in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The hardest state to reach from the ports is a master transfer frozen at an arbitrary half-bit with a sample pending. At that point a wrong hold of the timebase, the sampled bit or the shift register changes the bytes exchanged. Random clk_en gating on most master transfers drops the enable at many different points. One directed run also holds clk_en low for forty cycles and watches sck_out and sdo. The sample point cannot be seen while sdi is stable through the bit, so the bench peer drives one byte during the first half of each bit and another byte during the second half. The received byte then shows which point was used.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          en,
  input  logic          is_master,
  input  logic          cpol,
  input  logic          cke,
  input  logic          smp,
  input  logic [1:0]    div_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          clr_flags,
  output logic          buf_full,
  output logic          wcol,
  output logic          rxov,
  output logic          irq,
  output logic          sck_out,
  input  logic          sck_in,
  output logic          sdo,
  input  logic          sdi
);
  localparam int CW = $clog2(2*DW);
  localparam int BW = $clog2(DW);

  logic          busy;
  logic [4:0]    cnt;
  logic [CW-1:0] hcnt;
  logic [BW-1:0] scnt;
  logic [DW-1:0] shreg, rxbuf;
  logic          rxbit;
  logic [2:0]    sck_q;
  logic [1:0]    sdi_q;

  logic [4:0] half_lim;
  assign half_lim = (div_sel == 2'd0) ? 5'd1 : (div_sel == 2'd1) ? 5'd7 : 5'd31;

  logic tick, m_sample, m_shift, m_fin, m_in;
  assign tick     = en & is_master & busy & clk_en & (cnt == half_lim);
  assign m_sample = tick & ~hcnt[0] & ~smp;
  assign m_shift  = tick & hcnt[0];
  assign m_fin    = m_shift & (hcnt == CW'(2*DW-1));
  assign m_in     = smp ? sdi : rxbit;

  logic s_on, s_act, s_prev, lead, trail, s_last, s_sample, s_shift, s_fin, s_in;
  assign s_on     = en & ~is_master;
  assign s_act    = sck_q[1] ^ cpol;
  assign s_prev   = sck_q[2] ^ cpol;
  assign lead     = s_act & ~s_prev;
  assign trail    = ~s_act & s_prev;
  assign s_last   = (scnt == BW'(DW-1));
  assign s_sample = s_on & (cke ? lead : (trail & ~s_last));
  assign s_shift  = s_on & (cke ? trail : ((lead & (scnt != '0)) | (trail & s_last)));
  assign s_fin    = s_on & trail & s_last;
  assign s_in     = (cke | ~trail) ? rxbit : sdi_q[1];

  logic do_shift, in_bit, fin, do_sample, samp_bit, xfer_busy, wr_go, wr_col, keep_old;
  logic [DW-1:0] next_byte;
  assign do_shift  = m_shift | s_shift;
  assign in_bit    = m_shift ? m_in : s_in;
  assign fin       = m_fin | s_fin;
  assign do_sample = m_sample | s_sample;
  assign samp_bit  = m_sample ? sdi : sdi_q[1];
  assign next_byte = {shreg[DW-2:0], in_bit};
  assign xfer_busy = is_master ? busy : (scnt != '0);
  assign wr_go     = en & wr_en & ~xfer_busy;
  assign wr_col    = en & wr_en & xfer_busy;
  assign keep_old  = buf_full & ~rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      sdi_q <= '0;
      shreg <= '0;
      rxbit <= 1'b0;
      rxbuf <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck_in};
      sdi_q <= {sdi_q[0], sdi};
      if (wr_go)         shreg <= wr_data;
      else if (do_shift) shreg <= next_byte;
      if (do_sample)     rxbit <= samp_bit;
      if (fin && !keep_old) rxbuf <= next_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      hcnt <= '0;
    end else if (!en || !is_master) begin
      busy <= 1'b0;
      cnt  <= '0;
      hcnt <= '0;
    end else if (wr_go) begin
      busy <= 1'b1;
      cnt  <= '0;
      hcnt <= '0;
    end else if (busy && clk_en) begin
      if (cnt == half_lim) begin
        cnt  <= '0;
        hcnt <= hcnt + 1'b1;
        if (m_fin) busy <= 1'b0;
      end else begin
        cnt <= cnt + 5'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      scnt <= '0;
    else if (!s_on)  scnt <= '0;
    else if (trail)  scnt <= s_last ? '0 : scnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      wcol     <= 1'b0;
      rxov     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      buf_full <= fin | (buf_full & ~rd_en);
      wcol     <= wr_col | (wcol & ~clr_flags);
      rxov     <= (fin & keep_old) | (rxov & ~clr_flags);
      irq      <= fin | (irq & ~clr_flags);
    end
  end

  assign sck_out = (en & is_master & busy) ? (cpol ^ (cke ? hcnt[0] : ~hcnt[0])) : cpol;
  assign sdo     = shreg[DW-1];
  assign rd_data = rxbuf;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         is_master,
  input logic         clk_en,
  input logic         busy,
  input logic         wr_en,
  input logic         xfer_busy,
  input logic         wcol,
  input logic         fin,
  input logic         buf_full,
  input logic         rd_en,
  input logic         rxov,
  input logic         irq,
  input logic [W-1:0] rd_data,
  input logic         sck_out
);
  assert_hold_sck_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && is_master && busy && !clk_en) |=> (!en || $stable(sck_out)));

  assert_write_collision_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && xfer_busy) |=> wcol);

  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && buf_full && !rd_en) |=> (rxov && $stable(rd_data)));

  assert_complete_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (irq && buf_full));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !fin) |=> !$rose(irq));
endmodule

bind spi_port spi_port_chk #(.W(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .is_master(is_master), .clk_en(clk_en),
  .busy(busy), .wr_en(wr_en), .xfer_busy(xfer_busy), .wcol(wcol), .fin(fin),
  .buf_full(buf_full), .rd_en(rd_en), .rxov(rxov), .irq(irq),
  .rd_data(rd_data), .sck_out(sck_out)
);

// File: tb/sim_spi_port.sv
module sim_spi_port;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1, en = 1'b0, is_master = 1'b1;
  logic cpol = 1'b0, cke = 1'b0, smp = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic wr_en = 1'b0, rd_en = 1'b0, clr_flags = 1'b0, sck_in = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic buf_full, wcol, rxov, irq, sck_out, sdo, sdi;
  logic sdi_p = 1'b0, sdi_sl = 1'b0;
  assign sdi = is_master ? sdi_p : sdi_sl;

  spi_port u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .en(en), .is_master(is_master),
    .cpol(cpol), .cke(cke), .smp(smp), .div_sel(div_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .clr_flags(clr_flags),
    .buf_full(buf_full), .wcol(wcol), .rxov(rxov), .irq(irq), .sck_out(sck_out),
    .sck_in(sck_in), .sdo(sdo), .sdi(sdi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, gmode = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  always @(negedge clk)
    clk_en <= (gmode == 0) ? 1'b1 : (gmode == 1) ? ($urandom_range(0, 2) != 0) : 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rx(input logic s, input logic [7:0] a, input logic [7:0] b);
    return s ? b : a;
  endfunction

  function automatic int exp_cycles(input logic [1:0] d);
    return 8 * ((d == 2'd0) ? 4 : (d == 2'd1) ? 16 : 64);
  endfunction

  // bench peer on the master's bus
  logic peer_on = 1'b0;
  int pidx = 0, pmid = 0;
  logic [7:0] pa = 0, pb = 0, pcap = 0;
  always @(sck_out) begin
    if (peer_on && is_master) begin
      if ((sck_out ^ cpol) == cke) begin
        pcap = {pcap[6:0], sdo};
        pmid++;
        if (pidx < 8) sdi_p = pb[7-pidx];
      end else if (pmid > pidx) begin
        pidx++;
        if (pidx < 8) sdi_p = pa[7-pidx];
      end
    end
  end

  task automatic set_cfg(input logic m, input logic pol, input logic ph, input logic sm, input logic [1:0] dv);
    @(negedge clk);
    en = 1'b0; is_master = m; cpol = pol; cke = ph; smp = sm; div_sel = dv; sck_in = pol;
    repeat (4) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic m_start(input logic [7:0] tx, input logic [7:0] a, input logic [7:0] b);
    pa = a; pb = b; pidx = 0; pmid = 0; pcap = 0; sdi_p = a[7]; peer_on = 1'b1;
    wr_data = tx; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(input int lim, output int n);
    n = 0;
    while (!irq && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic host_read_clear();
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk("R9 buf_full cleared by read", buf_full, 1'b0);
    clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
    chk("R9 irq cleared", irq, 1'b0);
  endtask

  task automatic run_master(input logic pol, input logic ph, input logic sm, input logic [1:0] dv,
                            input logic [7:0] tx, input logic [7:0] a, input logic [7:0] b, input int gm);
    int n;
    set_cfg(1'b1, pol, ph, sm, dv);
    gmode = gm;
    m_start(tx, a, b);
    wait_irq(20000, n);
    gmode = 0; peer_on = 1'b0;
    if (gm == 0) chk("R5 transfer length", n, exp_cycles(dv));
    chk("R2 byte seen on sdo", pcap, tx);
    chk("R3 received byte", rd_data, exp_rx(sm, a, b));
    chk("R9 buf_full after completion", buf_full, 1'b1);
    chk("R9 sck idle after completion", sck_out, pol);
    host_read_clear();
  endtask

  task automatic run_slave(input logic pol, input logic ph, input logic [7:0] tx, input logic [7:0] rx, input int gm);
    logic [7:0] cap;
    set_cfg(1'b0, pol, ph, 1'b0, 2'd0);
    gmode = gm;
    sdi_sl = ph ? rx[7] : 1'b0;
    wr_data = tx; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    cap = 0;
    for (int k = 0; k < 8; k++) begin
      repeat (HP) @(negedge clk);
      sck_in = ~pol;
      if (ph) cap = {cap[6:0], sdo};
      else sdi_sl = rx[7-k];
      repeat (HP) @(negedge clk);
      sck_in = pol;
      if (ph) begin
        if (k < 7) sdi_sl = rx[6-k];
      end else cap = {cap[6:0], sdo};
    end
    repeat (6) @(negedge clk);
    gmode = 0;
    chk("R4 slave irq after 8 bits", irq, 1'b1);
    chk("R4 slave received byte", rd_data, rx);
    chk("R4 slave sent byte", cap, tx);
    host_read_clear();
  endtask

  initial begin
    int n;
    logic s0, d0, held;
    void'($urandom(32'h5eed));

    repeat (3) @(negedge clk);
    chk("R1 reset irq", irq, 1'b0);
    chk("R1 reset buf_full", buf_full, 1'b0);
    chk("R1 reset wcol", wcol, 1'b0);
    chk("R1 reset rxov", rxov, 1'b0);
    chk("R1 reset sck idle", sck_out, cpol);
    rst_n = 1'b1;

    for (int d = 0; d < 4; d++) run_master(1'b0, 1'b1, 1'b0, d[1:0], 8'hA5, 8'h3C, 8'h3C, 0);

    for (int m = 0; m < 8; m++)
      run_master(m[2], m[1], m[0], 2'd0, 8'h96 ^ 8'(m), 8'hC3, 8'h5A ^ 8'(m), 0);

    // R6 freeze mid transfer
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 2'd1);
    m_start(8'h6D, 8'hB2, 8'hB2);
    repeat (20) @(negedge clk);
    gmode = 2;
    repeat (2) @(negedge clk);
    s0 = sck_out; d0 = sdo; held = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sck_out !== s0 || sdo !== d0) held = 1'b0;
    end
    chk("R6 sck/sdo held while clock gated", held, 1'b1);
    chk("R6 no completion while gated", irq, 1'b0);
    gmode = 0;
    wait_irq(5000, n);
    peer_on = 1'b0;
    chk("R6 sent byte after resume", pcap, 8'h6D);
    chk("R6 received byte after resume", rd_data, 8'hB2);
    host_read_clear();

    // R7 write collision
    set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 2'd1);
    m_start(8'h81, 8'h4E, 8'h17);
    repeat (20) @(negedge clk);
    wr_data = 8'h00; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
    chk("R7 wcol set", wcol, 1'b1);
    wait_irq(5000, n);
    peer_on = 1'b0;
    chk("R7 sent byte untouched", pcap, 8'h81);
    chk("R7 received byte", rd_data, 8'h17);
    host_read_clear();
    chk("R9 wcol cleared", wcol, 1'b0);

    // R8 overflow
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    m_start(8'h11, 8'hE1, 8'hE1);
    wait_irq(5000, n);
    clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
    m_start(8'h22, 8'h1E, 8'h1E);
    wait_irq(5000, n);
    peer_on = 1'b0;
    chk("R8 overflow flag", rxov, 1'b1);
    chk("R8 old byte kept", rd_data, 8'hE1);
    chk("R8 irq on lost byte", irq, 1'b1);
    host_read_clear();
    chk("R9 rxov cleared", rxov, 1'b0);

    // R10 disable aborts
    set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 2'd1);
    m_start(8'hF0, 8'h0F, 8'h0F);
    repeat (18) @(negedge clk);
    peer_on = 1'b0;
    en = 1'b0;
    @(negedge clk);
    chk("R10 sck idle after disable", sck_out, 1'b1);
    repeat (200) @(negedge clk);
    chk("R10 no completion after abort", irq, 1'b0);
    chk("R10 no byte after abort", buf_full, 1'b0);
    run_master(1'b1, 1'b0, 1'b0, 2'd0, 8'h5C, 8'hA7, 8'hA7, 0);

    // R4 slave modes, clk_en independence
    run_slave(1'b0, 1'b1, 8'hC9, 8'h36, 0);
    run_slave(1'b0, 1'b0, 8'h2B, 8'hD4, 2);
    run_slave(1'b1, 1'b1, 8'h71, 8'h8E, 1);
    run_slave(1'b1, 1'b0, 8'h9A, 8'h65, 2);

    for (int i = 0; i < 24; i++) begin
      logic [1:0] dv;
      dv = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
      run_master(1'($urandom), 1'($urandom), 1'($urandom), dv, 8'($urandom), 8'($urandom),
                 8'($urandom), int'($urandom_range(0, 1)));
    end
    for (int i = 0; i < 8; i++)
      run_slave(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), int'($urandom_range(0, 2)));

    // R1 reset mid transfer
    set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 2'd1);
    m_start(8'h3A, 8'hC5, 8'hC5);
    wr_data = 8'h01; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
    repeat (24) @(negedge clk);
    peer_on = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 reset aborts sck", sck_out, 1'b1);
    chk("R1 reset clears wcol", wcol, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk("R1 no completion after reset", irq, 1'b0);
    run_master(1'b0, 1'b0, 1'b1, 2'd0, 8'hE7, 8'h18, 8'h42, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule